// File: doc/BRIEF.md
# Bank-Interleave Read Pattern Generator

This block drives a fixed, repeating command stream for a DDR2-style memory controller test mode. It visits every bank in turn. Each visit is an activate to that bank, followed in the next clock by a read with auto-precharge to the same bank. The stream runs at burst length 4. Deselect slots sit between the pairs and at the end of each loop, so that the row-cycle, activate-to-activate and four-activate-window limits hold at the selected speed grade. The block does not check any timing while it runs. It replays a spacing that is chosen per speed grade, CAS latency and bank count.

Software or a test controller sets the speed grade, the latency and the bank mode, then pulses start. The pattern then loops without end. A loop-end pulse marks the final slot of each loop. A stop request takes effect only at a loop boundary, so no bank is ever left open. A selection that is not supported raises an error flag, and the block stays quiet.

Top module: `ilv_read_pattern_gen`

## Requirements
- R1: After reset, cmd_o is 00, bank_o is 0, slot_o is 0, and loop_end_o, busy_o and cfg_err_o are all 0.
- R2: When start_i is sampled high while idle with a supported selection, the next clock shows an activate to bank 0 in slot 0. Every activate to bank n is followed in the very next clock by a read with auto-precharge to bank n. Banks are visited in ascending order from 0.
- R3: cmd_o encodes deselect as 00, activate as 01 and read with auto-precharge as 10. The code 11 never appears.
- R4: In four-bank mode (eight_bank_i=0), mid is the number of deselects after each of the first three pairs and tail is the number after the fourth pair. The values are:
  - speed 0: mid 0, tail 4 at CL3 and 5 at CL4.
  - speed 1: mid 1, tail 5.
  - speed 2: mid 2, tail 5 at CL4 and 6 at CL5.
  - speed 3: mid 2, tail 8, 9 or 10 at CL4, CL5 or CL6.
- R5: In eight-bank mode, banks form two groups of four pairs. Each group has mid deselects after each of its first three pairs and tail deselects after its fourth pair. The values are: speed 0 mid 0 tail 0; speed 1 mid 0 tail 2; speed 2 mid 1 tail 2; speed 3 mid 1 tail 3. This gives loops of 16, 20, 26 and 28 slots.
- R6: During every deselect slot, bank_o keeps the value it had in the previous clock, including while idle after a stop.
- R7: While busy, slot_o starts at 0 and rises by one each clock. loop_end_o is high only on the last slot of a loop, and the next slot is slot 0 again.
- R8: The loop repeats without end while no stop is pending, and busy_o stays high throughout.
- R9: A stop_i pulse seen while busy is remembered. The block finishes the current loop and then goes idle (busy_o=0, cmd_o=00). busy_o never falls except right after a loop-end slot.
- R10: latency_i holds CL-3. The supported latencies are: speed 0 with CL3 or CL4; speed 1 with CL4; speed 2 with CL4 or CL5; speed 3 with CL4, CL5 or CL6. These hold in both bank modes. A start with any other selection leaves the block idle, sends only deselects and sets cfg_err_o. The next start with a supported selection clears cfg_err_o.
- R11: While busy, changes on speed_i, latency_i, eight_bank_i and start_i have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch request, sampled while idle |
| stop_i | input | 1 | Stop request, takes effect at the loop boundary |
| speed_i | input | 2 | Speed grade select, 0 (slowest) to 3 (fastest) |
| latency_i | input | 2 | CAS latency minus 3 |
| eight_bank_i | input | 1 | 1 selects eight-bank mode, 0 selects four-bank mode |
| cmd_o | output | 2 | Command code of the current slot |
| bank_o | output | 3 | Bank address of the current slot |
| slot_o | output | 5 | Slot index within the loop |
| loop_end_o | output | 1 | High on the last slot of each loop |
| busy_o | output | 1 | Pattern running |
| cfg_err_o | output | 1 | Last start used an unsupported selection |

## Verification
The bench uses the default widths: a 4-bit gap counter, a 5-bit slot index and groups of four pairs. With these widths the full selection space is only 32 combinations of speed, latency and bank mode, so every one is launched. Each supported combination runs two complete loops and is checked slot by slot against a list built from the spacing tables. Each run also contains a mid-loop stop, a disturbed selection with a repeated start, and a check of the idle state afterwards. The unsupported combinations are interleaved with the supported ones, so the error flag is seen both rising and clearing.

// File: rtl/ilv_pkg.sv
// Package: shared command and phase encodings for the interleave generator.
// Assumes the 2-bit command code is decoded by the controller's command path.
package ilv_pkg;
    typedef enum logic [1:0] {
        CMD_DES = 2'b00,
        CMD_ACT = 2'b01,
        CMD_RDA = 2'b10
    } cmd_e;

    typedef enum logic [1:0] {
        PH_ACT = 2'b00,
        PH_RDA = 2'b01,
        PH_GAP = 2'b10
    } phase_e;
endpackage

// File: rtl/ilv_cfg_decode.sv
// Module: ilv_cfg_decode
// Turns speed grade, latency and bank mode into a validity flag and two gap
// counts: deselects after an inner pair and after the last pair of a group.
// Assumes latency is coded as CL-3. Purely combinational.
module ilv_cfg_decode #(
    parameter int GAP_W = 4
) (
    input  logic [1:0]       speed_i,
    input  logic [1:0]       latency_i,
    input  logic             eight_i,
    output logic             valid_o,
    output logic [GAP_W-1:0] mid_gap_o,
    output logic [GAP_W-1:0] end_gap_o
);
    // Table lookup of supported selections and their spacing.
    always_comb begin
        valid_o   = 1'b0;
        mid_gap_o = '0;
        end_gap_o = '0;
        unique case (speed_i)
            2'd0: begin
                valid_o   = (latency_i <= 2'd1);
                mid_gap_o = '0;
                end_gap_o = eight_i ? GAP_W'(0)
                                    : ((latency_i == 2'd0) ? GAP_W'(4) : GAP_W'(5));
            end
            2'd1: begin
                valid_o   = (latency_i == 2'd1);
                mid_gap_o = eight_i ? GAP_W'(0) : GAP_W'(1);
                end_gap_o = eight_i ? GAP_W'(2) : GAP_W'(5);
            end
            2'd2: begin
                valid_o   = (latency_i == 2'd1) || (latency_i == 2'd2);
                mid_gap_o = eight_i ? GAP_W'(1) : GAP_W'(2);
                end_gap_o = eight_i ? GAP_W'(2)
                                    : ((latency_i == 2'd1) ? GAP_W'(5) : GAP_W'(6));
            end
            default: begin
                valid_o   = (latency_i != 2'd0);
                mid_gap_o = eight_i ? GAP_W'(1) : GAP_W'(2);
                end_gap_o = eight_i ? GAP_W'(3) : (GAP_W'(latency_i) + GAP_W'(7));
            end
        endcase
    end
endmodule

// File: rtl/ilv_run_ctrl.sv
// Module: ilv_run_ctrl
// Idle/run control: accepts a start only while idle, records a configuration
// error, and holds a stop request until the sequencer reports a loop end.
// Assumes loop_last_i is high only on the final slot while running.
module ilv_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic cfg_valid_i,
    input  logic loop_last_i,
    output logic running_o,
    output logic cfg_err_o,
    output logic launch_o,
    output logic halt_o
);
    logic stop_pend_q;

    // A start is accepted only from idle with a legal selection.
    assign launch_o = !running_o && start_i && cfg_valid_i;
    // Stop is in effect if requested now or earlier in this loop.
    assign halt_o   = stop_i || stop_pend_q;

    // Run state, error flag and pending stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_o   <= 1'b0;
            cfg_err_o   <= 1'b0;
            stop_pend_q <= 1'b0;
        end else if (!running_o) begin
            stop_pend_q <= 1'b0;
            if (start_i) begin
                cfg_err_o <= !cfg_valid_i;
                running_o <= cfg_valid_i;
            end
        end else if (loop_last_i && halt_o) begin
            running_o   <= 1'b0;
            stop_pend_q <= 1'b0;
        end else if (stop_i) begin
            stop_pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ilv_slot_seq.sv
// Module: ilv_slot_seq
// Walks the activate / read-auto-precharge / deselect slots of one loop.
// Banks are grouped in sets of GROUP_PAIRS; eight-bank mode uses two groups.
// Spacing is latched at launch and held until the next launch.
// Assumes launch_i and run_i come from ilv_run_ctrl.
module ilv_slot_seq
    import ilv_pkg::*;
#(
    parameter int BANK_W      = 3,
    parameter int GAP_W       = 4,
    parameter int SLOT_W      = 5,
    parameter int GROUP_PAIRS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              run_i,
    input  logic              halt_i,
    input  logic [GAP_W-1:0]  mid_gap_i,
    input  logic [GAP_W-1:0]  end_gap_i,
    input  logic              eight_i,
    output cmd_e              cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              last_o
);
    localparam int POS_W = $clog2(GROUP_PAIRS);

    phase_e             phase_q;
    logic [GAP_W-1:0]   gap_q;
    logic [GAP_W-1:0]   mid_q;
    logic [GAP_W-1:0]   end_q;
    logic               eight_q;
    logic               grp_end;
    logic               bank_last;
    logic [GAP_W-1:0]   sel_gap;
    logic               pair_done;

    // Position of the current bank inside its group and the loop.
    always_comb begin
        grp_end   = (bank_o[POS_W-1:0] == POS_W'(GROUP_PAIRS - 1));
        bank_last = eight_q ? (bank_o == BANK_W'(2 * GROUP_PAIRS - 1))
                            : (bank_o == BANK_W'(GROUP_PAIRS - 1));
        sel_gap   = grp_end ? end_q : mid_q;
        pair_done = ((phase_q == PH_RDA) && (sel_gap == '0)) ||
                    ((phase_q == PH_GAP) && (gap_q == '0));
    end

    assign last_o = run_i && pair_done && bank_last;

    // Command code from the phase; deselect whenever idle.
    always_comb begin
        cmd_o = CMD_DES;
        if (run_i) begin
            unique case (phase_q)
                PH_ACT:  cmd_o = CMD_ACT;
                PH_RDA:  cmd_o = CMD_RDA;
                default: cmd_o = CMD_DES;
            endcase
        end
    end

    // Slot advance: pair, gap countdown, next bank or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ACT;
            bank_o  <= '0;
            gap_q   <= '0;
            slot_o  <= '0;
            mid_q   <= '0;
            end_q   <= '0;
            eight_q <= 1'b0;
        end else if (launch_i) begin
            phase_q <= PH_ACT;
            bank_o  <= '0;
            gap_q   <= '0;
            slot_o  <= '0;
            mid_q   <= mid_gap_i;
            end_q   <= end_gap_i;
            eight_q <= eight_i;
        end else if (run_i) begin
            if (pair_done) begin
                if (bank_last) begin
                    if (!halt_i) begin
                        phase_q <= PH_ACT;
                        bank_o  <= '0;
                        slot_o  <= '0;
                    end
                end else begin
                    phase_q <= PH_ACT;
                    bank_o  <= bank_o + BANK_W'(1);
                    slot_o  <= slot_o + SLOT_W'(1);
                end
            end else begin
                slot_o <= slot_o + SLOT_W'(1);
                unique case (phase_q)
                    PH_ACT:  phase_q <= PH_RDA;
                    PH_RDA: begin
                        phase_q <= PH_GAP;
                        gap_q   <= sel_gap - GAP_W'(1);
                    end
                    default: gap_q <= gap_q - GAP_W'(1);
                endcase
            end
        end
    end
endmodule

// File: rtl/ilv_read_pattern_gen.sv
// Module: ilv_read_pattern_gen (top)
// All-bank interleaved read command generator for a memory test mode.
// Assumes the command path applies the 2-bit code and bank address one
// command per clock; the selection inputs matter only at an accepted start.
module ilv_read_pattern_gen #(
    parameter int GAP_W       = 4,
    parameter int SLOT_W      = 5,
    parameter int GROUP_PAIRS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [1:0]        speed_i,
    input  logic [1:0]        latency_i,
    input  logic              eight_bank_i,
    output logic [1:0]        cmd_o,
    output logic [2:0]        bank_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              loop_end_o,
    output logic              busy_o,
    output logic              cfg_err_o
);
    localparam int BANK_W = 3;

    logic             cfg_valid;
    logic [GAP_W-1:0] mid_gap;
    logic [GAP_W-1:0] end_gap;
    logic             launch;
    logic             halt;
    ilv_pkg::cmd_e    cmd_code;

    ilv_cfg_decode #(.GAP_W(GAP_W)) u_decode (
        .speed_i   (speed_i),
        .latency_i (latency_i),
        .eight_i   (eight_bank_i),
        .valid_o   (cfg_valid),
        .mid_gap_o (mid_gap),
        .end_gap_o (end_gap)
    );

    ilv_run_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .cfg_valid_i (cfg_valid),
        .loop_last_i (loop_end_o),
        .running_o   (busy_o),
        .cfg_err_o   (cfg_err_o),
        .launch_o    (launch),
        .halt_o      (halt)
    );

    ilv_slot_seq #(
        .BANK_W      (BANK_W),
        .GAP_W       (GAP_W),
        .SLOT_W      (SLOT_W),
        .GROUP_PAIRS (GROUP_PAIRS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .run_i     (busy_o),
        .halt_i    (halt),
        .mid_gap_i (mid_gap),
        .end_gap_i (end_gap),
        .eight_i   (eight_bank_i),
        .cmd_o     (cmd_code),
        .bank_o    (bank_o),
        .slot_o    (slot_o),
        .last_o    (loop_end_o)
    );

    assign cmd_o = cmd_code;
endmodule

// File: rtl/ilv_read_pattern_chk.sv
// Module: ilv_read_pattern_chk
// Protocol checker bound to the top; watches ports only.
module ilv_read_pattern_chk #(
    parameter int SLOT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd_o,
    input logic [2:0]        bank_o,
    input logic [SLOT_W-1:0] slot_o,
    input logic              loop_end_o,
    input logic              busy_o,
    input logic              cfg_err_o
);
    assert_cmd_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o != 2'b11);

    assert_act_then_rda_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b01) |=> (cmd_o == 2'b10 && bank_o == $past(bank_o)));

    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b00) |-> $stable(bank_o));

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (cmd_o == 2'b00 && !busy_o));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loop_end_o |=> (!busy_o || (slot_o == '0 && cmd_o == 2'b01 && bank_o == 3'd0)));

    assert_slot_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !loop_end_o) |=> (busy_o && slot_o == $past(slot_o) + SLOT_W'(1)));

    assert_stop_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(loop_end_o));
endmodule

bind ilv_read_pattern_gen ilv_read_pattern_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_o      (cmd_o),
    .bank_o     (bank_o),
    .slot_o     (slot_o),
    .loop_end_o (loop_end_o),
    .busy_o     (busy_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/ilv_read_pattern_gen_bench.sv
// Bench: sweeps every speed / latency / bank-mode selection.
module ilv_read_pattern_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [1:0] speed_i = 2'd0;
    logic [1:0] latency_i = 2'd0;
    logic       eight_bank_i = 1'b0;
    logic [1:0] cmd_o;
    logic [2:0] bank_o;
    logic [4:0] slot_o;
    logic       loop_end_o;
    logic       busy_o;
    logic       cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int ecmd [0:31];
    int ebank[0:31];

    ilv_read_pattern_gen u_ilv_read_pattern_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .speed_i(speed_i), .latency_i(latency_i), .eight_bank_i(eight_bank_i),
        .cmd_o(cmd_o), .bank_o(bank_o), .slot_o(slot_o),
        .loop_end_o(loop_end_o), .busy_o(busy_o), .cfg_err_o(cfg_err_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Spacing tables taken from R4, R5 and R10 (cl is the true CAS latency).
    task automatic spacing(input int sp, input int cl, input bit e8,
                           output bit ok, output int mid, output int tail);
        ok = 1'b0; mid = 0; tail = 0;
        case (sp)
            0: begin ok = (cl == 3 || cl == 4); mid = 0; tail = e8 ? 0 : cl + 1; end
            1: begin ok = (cl == 4); mid = e8 ? 0 : 1; tail = e8 ? 2 : 5; end
            2: begin ok = (cl == 4 || cl == 5); mid = e8 ? 1 : 2; tail = e8 ? 2 : cl + 1; end
            default: begin ok = (cl >= 4); mid = e8 ? 1 : 2; tail = e8 ? 3 : cl + 4; end
        endcase
    endtask

    task automatic run_combo(input int sp, input int la, input bit e8);
        bit ok;
        int mid, tail, len, nb;
        string rq;
        spacing(sp, la + 3, e8, ok, mid, tail);
        nb = e8 ? 8 : 4;
        len = 0;
        for (int b = 0; b < nb; b++) begin
            ecmd[len] = 1; ebank[len] = b; len++;
            ecmd[len] = 2; ebank[len] = b; len++;
            for (int g = 0; g < (((b % 4) == 3) ? tail : mid); g++) begin
                ecmd[len] = 0; ebank[len] = b; len++;
            end
        end
        @(negedge clk);
        speed_i = 2'(sp); latency_i = 2'(la); eight_bank_i = e8; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (!ok) begin
            chk(cfg_err_o == 1'b1, "R10 err flag", cfg_err_o, 1);
            for (int k = 0; k < 3; k++) begin
                chk(cmd_o == 2'd0 && !busy_o, "R10 quiet", cmd_o, 0);
                @(negedge clk);
            end
            return;
        end
        chk(cfg_err_o == 1'b0, "R10 err clear", cfg_err_o, 0);
        chk(cmd_o == 2'd1 && bank_o == 3'd0, "R2 first act", cmd_o, 1);
        rq = e8 ? "R5 cmd" : "R4 cmd";
        for (int s = 0; s < 2 * len; s++) begin
            int idx;
            idx = s % len;
            chk(int'(cmd_o) == ecmd[idx], rq, cmd_o, ecmd[idx]);
            chk(cmd_o != 2'd3, "R3 code", cmd_o, 0);
            chk(int'(bank_o) == ebank[idx], (ecmd[idx] == 0) ? "R6 bank hold" : "R2 bank",
                bank_o, ebank[idx]);
            chk(int'(slot_o) == idx, "R7 slot", slot_o, idx);
            chk(loop_end_o == (idx == len - 1), "R7 loop end", loop_end_o, idx == len - 1);
            chk(busy_o == 1'b1, (s >= len) ? "R8 repeat" : "R9 busy", busy_o, 1);
            // R11: disturb selection and start while running
            if (s == 3) begin
                speed_i = ~speed_i; latency_i = ~latency_i; eight_bank_i = ~eight_bank_i;
                start_i = 1'b1;
            end
            if (s == 4) start_i = 1'b0;
            if (s == 5) begin
                speed_i = 2'(sp); latency_i = 2'(la); eight_bank_i = e8;
            end
            if (s == len + 1) stop_i = 1'b1;
            if (s == len + 2) stop_i = 1'b0;
            @(negedge clk);
        end
        chk(busy_o == 1'b0 && cmd_o == 2'd0, "R9 idle after stop", busy_o, 0);
        chk(int'(bank_o) == ebank[len - 1], "R6 idle bank hold", bank_o, ebank[len - 1]);
        chk(cfg_err_o == 1'b0, "R11 no err", cfg_err_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_o == 2'd0, "R1 cmd", cmd_o, 0);
        chk(bank_o == 3'd0, "R1 bank", bank_o, 0);
        chk(slot_o == 5'd0, "R1 slot", slot_o, 0);
        chk(!loop_end_o && !busy_o && !cfg_err_o, "R1 flags",
            {loop_end_o, busy_o, cfg_err_o}, 0);
        for (int sp = 0; sp < 4; sp++)
            for (int la = 0; la < 4; la++)
                for (int e = 0; e < 2; e++)
                    run_combo(sp, la, e[0]);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule